// File: doc/BRIEF.md
# SCL Stuck-Line Timeout Detector

This block watches the clock line of a two-wire serial bus and raises a fault when that line stays at one level for too long while a transfer is in progress. The raw SCL input passes through a two-flop synchronizer. Any change between two successive synchronized samples, taken on every system clock, restarts a counter. The counter advances only on cycles where the prescaled reference enable `tick` is high. It advances only while SCL sits at a level that the two level-select bits allow.

Counting is qualified by the bus state. The detector must be enabled, and at least one level must be selected. The bus must be busy. In slave operation, the own address must also have matched. When any of these conditions is false, the counter is held at zero, so each busy period starts a fresh count. The counter length is chosen by a mode bit: long (`LONG_W` bits, 16 by default) or short (`SHORT_W` bits, 14 by default).

When the counter overflows, the block emits a one-cycle pulse and sets a sticky status flag. The flag holds until `flag_clr` is asserted. After an overflow, the counter rests at its terminal value and does not fire again. It is re-armed by the next SCL edge or by the qualification dropping.

Top module: `scl_stuck_timeout`

## Requirements
- R1: After reset, `to_flag` and `to_pulse` are 0.
- R2: With counting qualified and SCL steady, the timeout fires on the 2^N-th qualifying tick after counting starts. N is `LONG_W` when `short_mode`=0 and `SHORT_W` when `short_mode`=1. Firing sets `to_flag` and raises `to_pulse` at that same clock edge.
- R3: The counter advances only on clock cycles where `tick` is 1; on other cycles its value holds.
- R4: A change of the synchronized SCL level restarts the count from zero. An `scl_in` change reaches the counter's clear three clock edges after it is driven.
- R5: With `to_en`=0, no timeout ever fires.
- R6: SCL low is counted only if `cnt_lo_en`=1, and SCL high only if `cnt_hi_en`=1. With both bits at 0, no timeout fires.
- R7: With `is_master`=1, counting needs `bus_busy`=1. With `is_master`=0, it needs both `bus_busy`=1 and `addr_match`=1.
- R8: A cycle in which qualification is false returns the count to zero, so a full 2^N ticks are again needed.
- R9: `to_pulse` is high for exactly one clock per timeout. `to_flag` stays 1 until cleared.
- R10: After a timeout, further ticks at the same SCL level do not fire again until an SCL edge or a loss of qualification.
- R11: `flag_clr`=1 clears `to_flag` at the next clock edge, unless a timeout fires on that same edge, in which case the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| tick | input | 1 | Prescaled reference-clock enable |
| bus_busy | input | 1 | Bus is in a transfer |
| is_master | input | 1 | 1 = master operation, 0 = slave |
| addr_match | input | 1 | Own slave address has matched |
| to_en | input | 1 | Timeout detection enable |
| short_mode | input | 1 | 0 = long counter, 1 = short counter |
| cnt_lo_en | input | 1 | Count while SCL is low |
| cnt_hi_en | input | 1 | Count while SCL is high |
| flag_clr | input | 1 | Clear the sticky timeout flag |
| to_pulse | output | 1 | One-cycle timeout event |
| to_flag | output | 1 | Sticky timeout status |

## Verification
The bench sweeps every combination of enable, length mode, level select, SCL level, master/slave, busy and match on a small counter configuration. At each combination it checks that the flag is still clear one tick before the expected overflow and set exactly at it. A design with an off-by-one terminal, a wrong slave qualifier or a swapped level select misses one of these samples.

Targeted sequences cover the remaining cases:
- A sparse tick pattern would fire early if the design counted raw cycles.
- An SCL toggle close to the terminal value would fire early if the design ignored the synchronized edge.
- A single-cycle busy drop would keep a stale count if the design only paused instead of clearing.
- A long idle period after an overflow exposes a counter that wraps and fires again.

// File: rtl/scl_to_pkg.sv
package scl_to_pkg;

  // Counting is permitted only in a busy transfer that concerns this node.
  function automatic logic qualifies(input logic en, input logic lo_en,
                                     input logic hi_en, input logic busy,
                                     input logic master, input logic match);
    return en & (lo_en | hi_en) & busy & (master | match);
  endfunction

  // The present SCL level must be one the software asked to watch.
  function automatic logic level_selected(input logic scl, input logic lo_en,
                                          input logic hi_en);
    return scl ? hi_en : lo_en;
  endfunction

endpackage

// File: rtl/scl_sync_edge.sv
module scl_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  output logic scl_sync,
  output logic scl_edge
);
  logic meta_q, sync_q, hist_q;

  // Idle bus level is high, so the chain resets to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      hist_q <= 1'b1;
    end else begin
      meta_q <= scl_raw;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign scl_sync = sync_q;
  assign scl_edge = sync_q ^ hist_q;
endmodule

// File: rtl/to_counter.sv
module to_counter #(
  parameter int LONG_W  = 16,
  parameter int SHORT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic              short_i,
  output logic [LONG_W-1:0] cnt_o,
  output logic              ovf_o
);
  localparam logic [LONG_W-1:0] LONG_TERM  = {LONG_W{1'b1}};
  localparam logic [LONG_W-1:0] SHORT_TERM = LONG_W'((64'd1 << SHORT_W) - 64'd1);

  logic [LONG_W-1:0] cnt_q;
  logic              sat_q;
  logic [LONG_W-1:0] term;
  logic              at_term;

  assign term    = short_i ? SHORT_TERM : LONG_TERM;
  // ">=" covers a switch from long to short mode in mid-count.
  assign at_term = (cnt_q >= term);
  assign ovf_o   = step_i & at_term & ~sat_q & ~clear_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sat_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0;
      sat_q <= 1'b0;
    end else if (step_i) begin
      if (at_term) sat_q <= 1'b1;
      else         cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/scl_stuck_timeout.sv
module scl_stuck_timeout #(
  parameter int LONG_W  = 16,
  parameter int SHORT_W = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic tick,
  input  logic bus_busy,
  input  logic is_master,
  input  logic addr_match,
  input  logic to_en,
  input  logic short_mode,
  input  logic cnt_lo_en,
  input  logic cnt_hi_en,
  input  logic flag_clr,
  output logic to_pulse,
  output logic to_flag
);
  import scl_to_pkg::*;

  logic              scl_s;
  logic              edge_w;
  logic              qual_w;
  logic              step_w;
  logic              ovf_w;
  logic [LONG_W-1:0] cnt_w;
  logic              pulse_q, flag_q;

  scl_sync_edge u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_raw  (scl_in),
    .scl_sync (scl_s),
    .scl_edge (edge_w)
  );

  assign qual_w = qualifies(to_en, cnt_lo_en, cnt_hi_en, bus_busy, is_master, addr_match);
  assign step_w = tick & level_selected(scl_s, cnt_lo_en, cnt_hi_en);

  to_counter #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (edge_w | ~qual_w),
    .step_i  (step_w),
    .short_i (short_mode),
    .cnt_o   (cnt_w),
    .ovf_o   (ovf_w)
  );

  // A timeout on the same edge as a clear wins over the clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= ovf_w;
      if (ovf_w)         flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign to_pulse = pulse_q;
  assign to_flag  = flag_q;
endmodule

// File: rtl/scl_to_chk.sv
module scl_to_chk #(
  parameter int LONG_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              flag_clr,
  input logic              edge_w,
  input logic              qual_w,
  input logic              ovf_w,
  input logic [LONG_W-1:0] cnt_w,
  input logic              to_pulse,
  input logic              to_flag
);
  // R9
  pulse_follows_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_w |=> to_pulse);
  // R9
  pulse_only_on_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_w |=> !to_pulse);
  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (to_flag && !flag_clr) |=> to_flag);
  // R11
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !ovf_w) |=> !to_flag);
  // R4
  edge_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_w |=> (cnt_w == '0));
  // R8
  unqualified_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !qual_w |=> (cnt_w == '0));
  // R3
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_w && !edge_w && !tick) |=> $stable(cnt_w));
  // R5 R7
  ovf_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_w |-> (qual_w && tick && !edge_w));
  // R10
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_w |=> !ovf_w);
endmodule

bind scl_stuck_timeout scl_to_chk #(.LONG_W(LONG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .flag_clr (flag_clr),
  .edge_w   (edge_w),
  .qual_w   (qual_w),
  .ovf_w    (ovf_w),
  .cnt_w    (cnt_w),
  .to_pulse (to_pulse),
  .to_flag  (to_flag)
);

// File: tb/sim_scl_stuck_timeout.sv
`timescale 1ns/1ps
module sim_scl_stuck_timeout;
  localparam int LW = 5;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, tick = 1'b0, bus_busy = 1'b0, is_master = 1'b0;
  logic addr_match = 1'b0, to_en = 1'b0, short_mode = 1'b0;
  logic cnt_lo_en = 1'b0, cnt_hi_en = 1'b0, flag_clr = 1'b0;
  logic to_pulse, to_flag;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scl_stuck_timeout #(.LONG_W(LW), .SHORT_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .tick(tick),
    .bus_busy(bus_busy), .is_master(is_master), .addr_match(addr_match),
    .to_en(to_en), .short_mode(short_mode), .cnt_lo_en(cnt_lo_en),
    .cnt_hi_en(cnt_hi_en), .flag_clr(flag_clr),
    .to_pulse(to_pulse), .to_flag(to_flag)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Drop busy, let the synchronizer settle, clear the flag; ends at a negedge.
  task automatic settle();
    @(negedge clk);
    bus_busy = 1'b0;
    flag_clr = 1'b1;
    repeat (4) @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 flag after reset", to_flag, 1'b0);
    chk("R1 pulse after reset", to_pulse, 1'b0);
    rst_n = 1'b1;

    // Sweep: R2 R5 R6 R7 R9
    for (int cfg = 0; cfg < 256; cfg++) begin
      logic m_short, m_scl, m_lo, m_hi, m_en, m_mst, m_busy, m_match, exp;
      int t;
      {m_short, m_scl, m_hi, m_lo, m_en, m_mst, m_busy, m_match} = 8'(cfg);
      @(negedge clk);
      tick = 1'b1;
      scl_in = m_scl; short_mode = m_short; cnt_lo_en = m_lo; cnt_hi_en = m_hi;
      to_en = m_en; is_master = m_mst; addr_match = m_match;
      settle();
      bus_busy = m_busy;
      exp = m_en && (m_lo || m_hi) && m_busy && (m_mst || m_match) && (m_scl ? m_hi : m_lo);
      t = m_short ? (1 << SW) : (1 << LW);
      for (int j = 1; j <= t + 1; j++) begin
        step();
        if (j == t - 1) chk("R2 R6 flag before terminal", to_flag, 1'b0);
        if (j == t) begin
          chk("R2 R5 R6 R7 flag at terminal", to_flag, exp);
          chk("R9 pulse at terminal", to_pulse, exp);
        end
        if (j == t + 1) chk("R9 pulse one cycle", to_pulse, 1'b0);
      end
    end

    // Common setup for the targeted cases: short mode, both levels, master.
    @(negedge clk);
    to_en = 1'b1; short_mode = 1'b1; cnt_lo_en = 1'b1; cnt_hi_en = 1'b1;
    is_master = 1'b1; addr_match = 1'b0; scl_in = 1'b0;

    // R3: a tick every third cycle.
    begin
      int tc = 0;
      int fire_j = 0;
      settle();
      bus_busy = 1'b1;
      for (int j = 1; j <= 40; j++) begin
        tick = (j % 3 == 0);
        if (tick) tc++;
        if (tc == (1 << SW) && fire_j == 0) fire_j = j;
        step();
        if (fire_j == 0) chk("R3 no flag before enough ticks", to_flag, 1'b0);
        else if (j == fire_j) chk("R3 flag on last tick", to_flag, 1'b1);
      end
      tick = 1'b1;
    end

    // R4: an SCL toggle before the terminal value restarts the count.
    settle();
    bus_busy = 1'b1;
    for (int j = 1; j <= (1 << SW) - 4; j++) step();
    scl_in = ~scl_in;
    for (int k = 0; k <= (1 << SW) + 2; k++) begin
      step();
      if (k == (1 << SW) + 1) chk("R4 no flag before restarted count ends", to_flag, 1'b0);
      if (k == (1 << SW) + 2) chk("R4 flag after restarted count", to_flag, 1'b1);
    end

    // R8: a single-cycle busy drop clears the count.
    settle();
    bus_busy = 1'b1;
    for (int j = 1; j <= (1 << SW) - 1; j++) step();
    bus_busy = 1'b0;
    step();
    bus_busy = 1'b1;
    for (int k = 1; k <= (1 << SW); k++) begin
      step();
      if (k == (1 << SW) - 1) chk("R8 no flag with stale count", to_flag, 1'b0);
      if (k == (1 << SW)) chk("R8 flag after fresh count", to_flag, 1'b1);
    end

    // R11: clear, then R10: no retrigger while SCL holds.
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
    chk("R11 flag cleared", to_flag, 1'b0);
    begin
      int seen = 0;
      for (int k = 0; k < (1 << SW) + 6; k++) begin
        step();
        if (to_flag || to_pulse) seen++;
      end
      chk("R10 no retrigger", logic'(seen != 0), 1'b0);
    end
    // R10: a loss of qualification re-arms the counter.
    bus_busy = 1'b0;
    step();
    bus_busy = 1'b1;
    for (int k = 1; k <= (1 << SW); k++) step();
    chk("R10 re-armed after requalify", to_flag, 1'b1);

    // R11: a clear on the firing edge loses to the timeout.
    settle();
    bus_busy = 1'b1;
    for (int j = 1; j <= (1 << SW) - 1; j++) step();
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
    chk("R11 timeout wins over clear", to_flag, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule